// File: doc/BRIEF.md
# Chained Capture-to-Memory Engine

This block writes a stream of byte-wide converter samples into a physically contiguous memory region. Software describes the region with two registers: the address of its first byte and the address of its last byte. A run bit in a control register starts and stops capture. Each accepted sample goes out on a simple memory write port, with valid/ready handshaking, an address and a byte of data. The address starts at the region's first byte and rises by one for every accepted write. When the byte at the last address is accepted, a level interrupt goes high. It stays high until software clears it.

To avoid a gap between buffers, software can write a new first-byte address while capture is running. That address is held in a single pending slot. When the current region completes, the engine moves straight on to the pending region in the same cycle, so the next sample already goes to the new address. If nothing is pending, the engine returns to idle and its run status drops. At most two regions exist at any time: the active one and the pending one.

The engine has two states. **IDLE** waits for a run command. **FILL** forwards samples to memory. The transitions are:
- **LAUNCH** (IDLE to FILL): a control write with the run bit set.
- **HALT** (FILL to IDLE): a control write with the run bit clear.
- **CHAIN** (FILL to FILL): the last byte is accepted while a region is pending.
- **FINISH** (FILL to IDLE): the last byte is accepted and nothing is pending.

Top module: `cap_dma`

## Requirements
- R1: After reset, run_active, irq, ovf and mem_valid are all 0.
- R2: The register map is: reg_addr 0 is the first-byte address, reg_addr 1 is the last-byte address, and reg_addr 2 is control. In the control word, bit 0 is run (1 starts capture from IDLE, 0 halts it), bit 1 clears the interrupt, and bit 2 clears the overflow flag.
- R3: While idle, samples are ignored: mem_valid stays 0 and ovf does not change.
- R4: While running, mem_valid follows smp_valid in the same cycle and mem_data equals smp_data. After a start, the first accepted write goes to the first-byte address. Each later accepted write goes to the previous address plus 1.
- R5: A region covers its first-byte address through its last-byte address, both included. irq goes high on the clock edge that accepts the write to the last-byte address.
- R6: irq stays high until a control write with bit 1 set. If the completion of a region and the clear write happen in the same cycle, the completion wins and irq stays high.
- R7: If no region is pending when a region completes, run_active falls on that same edge and no further writes are issued.
- R8: A first-byte address written while running arms a pending region. When the current region completes, the next accepted write goes to the pending address with no idle cycle, and run_active stays 1. The new region's last-byte address is taken from the last-byte register at the moment of the switch.
- R9: Only one region can be pending. A second first-byte write while a region is pending replaces it. Switching to the pending region consumes it, so the following completion stops capture unless a new address was written.
- R10: A sample that arrives while running and mem_ready is 0 is dropped. The address does not advance, and ovf goes high. ovf stays high until a control write with bit 2 set.
- R11: A control write with run = 0 stops capture on that edge and discards any pending region. A later start begins at the first-byte register's value and does not chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | ADDR_W | Register write data |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | 8 | Sample byte |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | ADDR_W | Byte address of the write |
| mem_data | output | 8 | Byte to write |
| irq | output | 1 | Region-complete interrupt (level) |
| ovf | output | 1 | Sticky dropped-sample flag |
| run_active | output | 1 | Capture running |

## Verification
The memory request is combinational. A sample driven in a cycle therefore appears on mem_valid, mem_addr and mem_data in that same cycle. The scoreboard monitor compares these at the falling edge, before the accepting rising edge.

Register writes, irq, ovf and run_active all take effect on the first rising edge after the stimulus. Each driver task therefore returns just after that edge, and the bench checks the state there. The same applies to chaining: the write immediately after a completion is expected at the pending address with no cycle in between.

// File: rtl/cap_dma_pkg.sv
package cap_dma_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } cap_state_e;

    localparam logic [1:0] RA_START = 2'd0;
    localparam logic [1:0] RA_STOP  = 2'd1;
    localparam logic [1:0] RA_CTL   = 2'd2;

    localparam int CB_RUN    = 0;
    localparam int CB_IRQCLR = 1;
    localparam int CB_OVFCLR = 2;
endpackage

// File: rtl/cap_dma_regs.sv
module cap_dma_regs
    import cap_dma_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic              running,
    input  logic              consume,
    output logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] stop_addr,
    output logic              pend_valid,
    output logic [ADDR_W-1:0] pend_addr,
    output logic              go_req,
    output logic              halt_req,
    output logic              irq_clr,
    output logic              ovf_clr
);
    logic ctl_wr;
    logic start_wr;

    always_comb begin
        ctl_wr   = reg_we && (reg_addr == RA_CTL);
        start_wr = reg_we && (reg_addr == RA_START);
        go_req   = ctl_wr &&  reg_wdata[CB_RUN];
        halt_req = ctl_wr && !reg_wdata[CB_RUN];
        irq_clr  = ctl_wr &&  reg_wdata[CB_IRQCLR];
        ovf_clr  = ctl_wr &&  reg_wdata[CB_OVFCLR];
    end

    // Programmed region bounds
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_addr <= '0;
            stop_addr  <= '0;
        end else if (reg_we) begin
            if (reg_addr == RA_START) start_addr <= reg_wdata;
            if (reg_addr == RA_STOP)  stop_addr  <= reg_wdata;
        end
    end

    // Single pending-region slot: armed only while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_addr  <= '0;
        end else if (start_wr && running && !halt_req) begin
            pend_valid <= 1'b1;
            pend_addr  <= reg_wdata;
        end else if (consume || !running || halt_req) begin
            pend_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/cap_dma_fsm.sv
module cap_dma_fsm
    import cap_dma_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_req,
    input  logic              halt_req,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] stop_addr,
    input  logic              pend_valid,
    input  logic [ADDR_W-1:0] pend_addr,
    input  logic              smp_valid,
    input  logic              mem_ready,
    output logic              running,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              consume,
    output logic              region_done,
    output logic              drop
);
    cap_state_e        state_q, state_d;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] last_q;
    logic              accept;
    logic              load_start;
    logic              load_pend;

    // Outputs of the state machine
    always_comb begin
        running     = (state_q == ST_FILL);
        mem_valid   = running && smp_valid;
        mem_addr    = ptr_q;
        accept      = mem_valid && mem_ready;
        region_done = accept && (ptr_q == last_q);
        drop        = mem_valid && !mem_ready;
    end

    // Transitions: LAUNCH, HALT, CHAIN, FINISH
    always_comb begin
        state_d    = state_q;
        load_start = 1'b0;
        load_pend  = 1'b0;
        consume    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (go_req) begin
                    state_d    = ST_FILL;
                    load_start = 1'b1;
                end
            end
            ST_FILL: begin
                if (halt_req) begin
                    state_d = ST_IDLE;
                end else if (region_done) begin
                    if (pend_valid) begin
                        load_pend = 1'b1;
                        consume   = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            last_q <= '0;
        end else if (load_start) begin
            ptr_q  <= start_addr;
            last_q <= stop_addr;
        end else if (load_pend) begin
            ptr_q  <= pend_addr;
            last_q <= stop_addr;
        end else if (accept) begin
            ptr_q  <= ptr_q + 1'b1;
        end
    end
endmodule

// File: rtl/cap_dma_flags.sv
module cap_dma_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic region_done,
    input  logic irq_clr,
    input  logic drop,
    input  logic ovf_clr,
    output logic irq,
    output logic ovf
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
            ovf <= 1'b0;
        end else begin
            if (region_done)  irq <= 1'b1;
            else if (irq_clr) irq <= 1'b0;
            if (drop)         ovf <= 1'b1;
            else if (ovf_clr) ovf <= 1'b0;
        end
    end
endmodule

// File: rtl/cap_dma.sv
module cap_dma #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic              smp_valid,
    input  logic [7:0]        smp_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_data,
    output logic              irq,
    output logic              ovf,
    output logic              run_active
);
    logic [ADDR_W-1:0] start_addr;
    logic [ADDR_W-1:0] stop_addr;
    logic [ADDR_W-1:0] pend_addr;
    logic              pend_valid;
    logic              go_req;
    logic              halt_req;
    logic              irq_clr;
    logic              ovf_clr;
    logic              consume;
    logic              region_done;
    logic              drop;

    assign mem_data = smp_data;

    cap_dma_regs #(.ADDR_W(ADDR_W)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .running    (run_active),
        .consume    (consume),
        .start_addr (start_addr),
        .stop_addr  (stop_addr),
        .pend_valid (pend_valid),
        .pend_addr  (pend_addr),
        .go_req     (go_req),
        .halt_req   (halt_req),
        .irq_clr    (irq_clr),
        .ovf_clr    (ovf_clr)
    );

    cap_dma_fsm #(.ADDR_W(ADDR_W)) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_req      (go_req),
        .halt_req    (halt_req),
        .start_addr  (start_addr),
        .stop_addr   (stop_addr),
        .pend_valid  (pend_valid),
        .pend_addr   (pend_addr),
        .smp_valid   (smp_valid),
        .mem_ready   (mem_ready),
        .running     (run_active),
        .mem_valid   (mem_valid),
        .mem_addr    (mem_addr),
        .consume     (consume),
        .region_done (region_done),
        .drop        (drop)
    );

    cap_dma_flags i_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .region_done (region_done),
        .irq_clr     (irq_clr),
        .drop        (drop),
        .ovf_clr     (ovf_clr),
        .irq         (irq),
        .ovf         (ovf)
    );
endmodule

// File: rtl/cap_dma_chk.sv
module cap_dma_chk
    import cap_dma_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [1:0]        reg_addr,
    input logic [ADDR_W-1:0] reg_wdata,
    input logic              smp_valid,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              irq,
    input logic              ovf,
    input logic              run_active
);
    logic ctl_wr;
    assign ctl_wr = reg_we && (reg_addr == RA_CTL);

    a_r3_no_write_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> run_active);

    a_r4_request_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> smp_valid);

    a_r5_irq_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(mem_valid && mem_ready));

    a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(ctl_wr && reg_wdata[CB_IRQCLR])) |=> irq);

    a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_active && !(ctl_wr && reg_wdata[CB_RUN])) |=> !run_active);

    a_r10_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (run_active && smp_valid && !mem_ready) |=> ovf);

    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(ctl_wr && reg_wdata[CB_OVFCLR])) |=> ovf);
endmodule

bind cap_dma cap_dma_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .smp_valid  (smp_valid),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .irq        (irq),
    .ovf        (ovf),
    .run_active (run_active)
);

// File: tb/test_cap_dma.sv
module test_cap_dma;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          reg_we;
    logic [1:0]    reg_addr;
    logic [AW-1:0] reg_wdata;
    logic          smp_valid;
    logic [7:0]    smp_data;
    logic          mem_valid;
    logic          mem_ready;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_data;
    logic          irq;
    logic          ovf;
    logic          run_active;

    int checks = 0;
    int errors = 0;
    logic [AW+7:0] exp_q[$];
    logic [7:0]    seq = 8'h40;

    always #(CLK_PERIOD/2) clk = ~clk;

    cap_dma #(.ADDR_W(AW)) i_cap_dma (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .smp_valid(smp_valid), .smp_data(smp_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .irq(irq), .ovf(ovf), .run_active(run_active)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: compare every accepted write against the scoreboard
    always @(negedge clk) begin
        if (rst_n && mem_valid && mem_ready) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R4: actual write %0h expected none", mem_addr);
            end else begin
                logic [AW+7:0] e;
                e = exp_q.pop_front();
                if ({mem_addr, mem_data} !== e) begin
                    errors++;
                    $display("FAIL R4/R8: actual %0h expected %0h", {mem_addr, mem_data}, e);
                end
            end
        end
    end

    task automatic reg_wr(input logic [1:0] a, input logic [AW-1:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    // Driver: one sample; queue the expected write when it will be taken
    task automatic sample(input logic rdy, input logic [AW-1:0] exp_addr, input logic expect_wr);
        smp_valid = 1'b1; smp_data = seq; mem_ready = rdy;
        if (expect_wr) exp_q.push_back({exp_addr, seq});
        seq = seq + 8'd3;
        @(posedge clk); #1;
        smp_valid = 1'b0; mem_ready = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        smp_valid = 1'b0; smp_data = '0; mem_ready = 1'b1;
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 run", run_active, 0);
        check("R1 irq", irq, 0);
        check("R1 ovf", ovf, 0);
        check("R1 mem_valid", mem_valid, 0);
        @(posedge clk); #1;

        // R3: idle sample, ready low: no write, no overflow
        smp_valid = 1'b1; mem_ready = 1'b0;
        #(CLK_PERIOD/4);
        check("R3 mem_valid idle", mem_valid, 0);
        @(posedge clk); #1;
        smp_valid = 1'b0; mem_ready = 1'b1;
        check("R3 ovf idle", ovf, 0);

        // R2/R4/R5/R7/R10: single region 0x100..0x103
        reg_wr(2'd0, 16'h0100);
        reg_wr(2'd1, 16'h0103);
        reg_wr(2'd2, 16'h0001);
        check("R2 run start", run_active, 1);
        sample(1'b1, 16'h0100, 1'b1);
        sample(1'b1, 16'h0101, 1'b1);
        sample(1'b0, 16'h0000, 1'b0);
        check("R10 ovf set", ovf, 1);
        sample(1'b1, 16'h0102, 1'b1);
        check("R5 irq not early", irq, 0);
        sample(1'b1, 16'h0103, 1'b1);
        check("R5 irq at last", irq, 1);
        check("R7 run falls", run_active, 0);
        sample(1'b1, 16'h0000, 1'b0);
        check("R7 no more writes", exp_q.size(), 0);

        reg_wr(2'd2, 16'h0004);
        check("R10 ovf cleared", ovf, 0);
        check("R6 irq holds", irq, 1);
        reg_wr(2'd2, 16'h0002);
        check("R6 irq cleared", irq, 0);
        check("R2 clear keeps idle", run_active, 0);

        // R8/R9: chain 0x200..0x201 into 0x300..0x302
        reg_wr(2'd0, 16'h0200);
        reg_wr(2'd1, 16'h0201);
        reg_wr(2'd2, 16'h0001);
        reg_wr(2'd0, 16'h0300);
        reg_wr(2'd1, 16'h0302);
        sample(1'b1, 16'h0200, 1'b1);
        sample(1'b1, 16'h0201, 1'b1);
        check("R8 irq on first region", irq, 1);
        check("R8 run kept", run_active, 1);
        sample(1'b1, 16'h0300, 1'b1);
        sample(1'b1, 16'h0301, 1'b1);
        check("R8 run in second", run_active, 1);
        sample(1'b1, 16'h0302, 1'b1);
        check("R9 consumed stops", run_active, 0);
        reg_wr(2'd2, 16'h0002);

        // R9: replacement of pending, one-byte region
        reg_wr(2'd0, 16'h0010);
        reg_wr(2'd1, 16'h0010);
        reg_wr(2'd2, 16'h0001);
        reg_wr(2'd0, 16'h0400);
        reg_wr(2'd0, 16'h0500);
        reg_wr(2'd1, 16'h0501);
        sample(1'b1, 16'h0010, 1'b1);
        check("R9 one-byte irq", irq, 1);
        sample(1'b1, 16'h0500, 1'b1);
        sample(1'b1, 16'h0501, 1'b1);
        check("R9 replaced then stop", run_active, 0);
        reg_wr(2'd2, 16'h0002);

        // R11: halt discards pending, restart begins at start register
        reg_wr(2'd0, 16'h0600);
        reg_wr(2'd1, 16'h06FF);
        reg_wr(2'd2, 16'h0001);
        sample(1'b1, 16'h0600, 1'b1);
        reg_wr(2'd0, 16'h0700);
        reg_wr(2'd2, 16'h0000);
        check("R11 halt", run_active, 0);
        check("R11 no irq on halt", irq, 0);
        reg_wr(2'd1, 16'h0701);
        reg_wr(2'd2, 16'h0001);
        sample(1'b1, 16'h0700, 1'b1);
        sample(1'b1, 16'h0701, 1'b1);
        check("R11 no chain after halt", run_active, 0);

        // R6: completion and clear in the same cycle, completion wins
        reg_wr(2'd2, 16'h0002);
        reg_wr(2'd0, 16'h0800);
        reg_wr(2'd1, 16'h0800);
        reg_wr(2'd2, 16'h0001);
        reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 16'h0003;
        sample(1'b1, 16'h0800, 1'b1);
        reg_we = 1'b0;
        check("R6 set beats clear", irq, 1);

        @(posedge clk); #1;
        check("R4 scoreboard drained", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule